// File: doc/BRIEF.md
# Page Translation Unit with Table Walk on Miss

This block turns a logical address into a physical address for a memory system split into equal-size pages. The upper bits of the logical address name a page and the lower bits an offset. A small, fully associative translation cache holds recent page-to-frame mappings, and every slot compares its page number with the incoming page at the same time. On a hit the frame number is joined to the unchanged offset and the answer appears one cycle after the request is accepted, with no memory traffic.

On a miss the block issues a single read of a page-table word. The page table holds one entry per page and is indexed directly by page number, starting at an address held in a base register. When the entry comes back the block completes the translation and, if the entry is valid, stores it in the cache. Each entry carries separate read, write and execute rights, which are checked against the kind of access. A refused access or an invalid entry gives a fault response instead of an address. Writing the base register, as on a switch between processes, empties the cache.

Top module: `pg_xlate`

## Requirements
- R1: A successful response gives rsp_paddr = {frame, offset}: the frame number sits above the offset, and the low OFF_W bits of req_vaddr come back unchanged.
- R2: When the page is cached, rsp_valid is high in the cycle right after acceptance, and no memory read is issued.
- R3: When the page is not cached, exactly one mem_rd_req pulse is issued, at word address base + page number. The response follows after mem_rsp_valid.
- R4: A page-table word has the frame in bits [PFN_W-1:0], read right in bit PFN_W, write right in PFN_W+1, execute right in PFN_W+2 and the valid flag in PFN_W+3.
- R5: Access kind 0 needs the read right, kind 1 the write right and kind 2 the execute right. Kind 3 is always refused. A refused access returns rsp_perm_fault=1 with rsp_paddr=0.
- R6: A fetched word with the valid flag clear returns rsp_page_fault=1 with rsp_paddr=0, whatever the kind. It is not cached, so the next access to that page reads memory again. The two fault flags are never both set.
- R7: A valid fetched word is cached even when the access it served was refused. A later access to the same page then hits.
- R8: A fill goes to the lowest-numbered empty slot. When no slot is empty, it goes to a round-robin pointer, which then advances by one and wraps. Each page sits in at most one slot.
- R9: Writing the base register empties every slot and sets the pointer to slot 0. While base_we is high no request is accepted.
- R10: Only one translation is in progress at a time. req_ready is low while a table read is outstanding.
- R11: After reset, rsp_valid and mem_rd_req are low, req_ready is high and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_we | input | 1 | Write the page table base register and flush the cache |
| base_wdata | input | MEM_AW | New page table base word address |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_vaddr | input | VPN_W+OFF_W | Logical address: page number above offset |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, zero on a fault |
| rsp_perm_fault | output | 1 | Access kind not permitted by the entry |
| rsp_page_fault | output | 1 | Page table entry not valid |
| mem_rd_req | output | 1 | One-cycle page-table read strobe |
| mem_rd_addr | output | MEM_AW | Page-table word address |
| mem_rsp_valid | input | 1 | Read data valid, at least one cycle after mem_rd_req |
| mem_rsp_data | input | PFN_W+4 | Page-table word |

## Verification
Every cycle, the assertions check the following. The hit path answers in one cycle without a read. A miss produces a single read strobe. The offset survives translation. A fault never carries an address. The two fault flags exclude each other. At most one slot matches a page. A base write leaves the cache empty. Which slot a fill evicts, which fetched entries are kept, and whether the frame and rights are decoded correctly from the table word can only be seen over sequences of accesses. The bench covers these by sweeping every page, offset and access kind, by using two page tables, and by running a replacement order with hit and miss outcomes known in advance.

// File: rtl/xl_pkg.sv
package xl_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_ISSUE,
    WK_WAIT
  } wk_state_e;

  // rights in table-word order: r lowest, x highest
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rwx_t;

  function automatic logic rights_grant(rwx_t p, logic [1:0] kind);
    case (kind)
      ACC_RD:  return p.r;
      ACC_WR:  return p.w;
      ACC_EX:  return p.x;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xl_tlb_array.sv
module xl_tlb_array
  import xl_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 4,
  parameter int PFN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PFN_W-1:0]   lk_pfn,
  output rwx_t               lk_rwx,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  rwx_t               fill_rwx,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] valid_vec
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  rwx_t               perm_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   victim;
  logic               any_free;

  // parallel compare, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_vpn);
  end

  assign lk_hit    = |hit_vec;
  assign valid_vec = vld_q;

  always_comb begin
    lk_pfn = '0;
    lk_rwx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_pfn = lk_pfn | pfn_q[i];
        lk_rwx = rwx_t'(lk_rwx | perm_q[i]);
      end
    end
  end

  // lowest empty slot wins, otherwise the round-robin pointer
  always_comb begin
    victim   = rr_q;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        victim   = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (fill_en) begin
      vld_q[victim] <= 1'b1;
      if (!any_free)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[victim]  <= fill_vpn;
      pfn_q[victim]  <= fill_pfn;
      perm_q[victim] <= fill_rwx;
    end
  end

endmodule

// File: rtl/xl_walk_ctrl.sv
module xl_walk_ctrl
  import xl_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] start_addr,
  input  logic              mem_rsp_valid,
  output logic              busy,
  output logic              mem_rd_req,
  output logic [MEM_AW-1:0] mem_rd_addr,
  output logic              done
);
  wk_state_e         st_q;
  logic [MEM_AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      addr_q <= '0;
    end else begin
      case (st_q)
        WK_IDLE: if (start) begin
          st_q   <= WK_ISSUE;
          addr_q <= start_addr;
        end
        WK_ISSUE: st_q <= mem_rsp_valid ? WK_IDLE : WK_WAIT;
        WK_WAIT:  if (mem_rsp_valid) st_q <= WK_IDLE;
        default:  st_q <= WK_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != WK_IDLE);
  assign mem_rd_req  = (st_q == WK_ISSUE);
  assign mem_rd_addr = addr_q;
  assign done        = busy && mem_rsp_valid;

endmodule

// File: rtl/pg_xlate.sv
module pg_xlate
  import xl_pkg::*;
#(
  parameter int VPN_W   = 4,
  parameter int OFF_W   = 4,
  parameter int PFN_W   = 4,
  parameter int ENTRIES = 4,
  parameter int MEM_AW  = 8,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int PTE_W  = PFN_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [MEM_AW-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_perm_fault,
  output logic              rsp_page_fault,
  output logic              mem_rd_req,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);
  localparam int VLD_BIT = PFN_W + 3;

  function automatic logic [PA_W-1:0] join_pa(logic [PFN_W-1:0] f, logic [OFF_W-1:0] o);
    return {f, o};
  endfunction

  function automatic logic [MEM_AW-1:0] pte_loc(logic [MEM_AW-1:0] b, logic [VPN_W-1:0] v);
    return b + MEM_AW'(v);
  endfunction

  logic [MEM_AW-1:0] base_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        kind_q;
  logic              stale_q;

  logic [VPN_W-1:0]   in_vpn;
  logic [OFF_W-1:0]   in_off;
  logic               lk_hit_w;
  logic [PFN_W-1:0]   lk_pfn_w;
  rwx_t               lk_rwx_w;
  logic [ENTRIES-1:0] hit_vec_w;
  logic [ENTRIES-1:0] valid_vec_w;
  logic               walk_busy_w;
  logic               walk_done_w;
  logic               accept_w;
  logic               hit_acc_w;
  logic               miss_acc_w;
  logic               fill_w;
  logic [PFN_W-1:0]   pte_pfn;
  rwx_t               pte_rwx;
  logic               pte_vld;

  assign in_vpn = req_vaddr[VA_W-1:OFF_W];
  assign in_off = req_vaddr[OFF_W-1:0];

  assign req_ready  = !walk_busy_w && !base_we;
  assign accept_w   = req_valid && req_ready;
  assign hit_acc_w  = accept_w && lk_hit_w;
  assign miss_acc_w = accept_w && !lk_hit_w;

  assign pte_pfn = mem_rsp_data[PFN_W-1:0];
  assign pte_rwx = rwx_t'(mem_rsp_data[PFN_W+2:PFN_W]);
  assign pte_vld = mem_rsp_data[VLD_BIT];
  // a base change during the walk makes the fetched word belong to the old table
  assign fill_w  = walk_done_w && pte_vld && !stale_q && !base_we;

  xl_tlb_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) tlb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (base_we),
    .lk_vpn    (in_vpn),
    .lk_hit    (lk_hit_w),
    .lk_pfn    (lk_pfn_w),
    .lk_rwx    (lk_rwx_w),
    .fill_en   (fill_w),
    .fill_vpn  (vpn_q),
    .fill_pfn  (pte_pfn),
    .fill_rwx  (pte_rwx),
    .hit_vec   (hit_vec_w),
    .valid_vec (valid_vec_w)
  );

  xl_walk_ctrl #(
    .MEM_AW (MEM_AW)
  ) walk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (miss_acc_w),
    .start_addr    (pte_loc(base_q, in_vpn)),
    .mem_rsp_valid (mem_rsp_valid),
    .busy          (walk_busy_w),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_addr   (mem_rd_addr),
    .done          (walk_done_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      vpn_q   <= '0;
      off_q   <= '0;
      kind_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      if (base_we) base_q <= base_wdata;
      if (accept_w) begin
        vpn_q  <= in_vpn;
        off_q  <= in_off;
        kind_q <= req_kind;
      end
      if (base_we)       stale_q <= 1'b1;
      else if (accept_w) stale_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_perm_fault <= 1'b0;
      rsp_page_fault <= 1'b0;
    end else begin
      rsp_valid      <= hit_acc_w || walk_done_w;
      rsp_paddr      <= '0;
      rsp_perm_fault <= 1'b0;
      rsp_page_fault <= 1'b0;
      if (hit_acc_w) begin
        if (rights_grant(lk_rwx_w, req_kind)) rsp_paddr <= join_pa(lk_pfn_w, in_off);
        else                                   rsp_perm_fault <= 1'b1;
      end else if (walk_done_w) begin
        if (!pte_vld)                          rsp_page_fault <= 1'b1;
        else if (rights_grant(pte_rwx, kind_q)) rsp_paddr <= join_pa(pte_pfn, off_q);
        else                                   rsp_perm_fault <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pg_xlate_chk.sv
module pg_xlate_chk #(
  parameter int VA_W    = 8,
  parameter int OFF_W   = 4,
  parameter int PA_W    = 8,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               base_we,
  input logic               req_ready,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               rsp_valid,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               rsp_perm_fault,
  input logic               rsp_page_fault,
  input logic               mem_rd_req,
  input logic               accept_w,
  input logic               lk_hit_w,
  input logic [ENTRIES-1:0] hit_vec_w,
  input logic [ENTRIES-1:0] valid_vec_w
);
  logic [OFF_W-1:0] exp_off;

  always_ff @(posedge clk) begin
    if (!rst_n)        exp_off <= '0;
    else if (accept_w) exp_off <= req_vaddr[OFF_W-1:0];
  end

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && lk_hit_w |=> rsp_valid); // R2
  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && lk_hit_w |=> !mem_rd_req); // R2
  AST_MISS_READS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !lk_hit_w |=> mem_rd_req); // R3
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req); // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_perm_fault && !rsp_page_fault |-> rsp_paddr[OFF_W-1:0] == exp_off); // R1
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_perm_fault || rsp_page_fault) |-> rsp_paddr == '0); // R5
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_perm_fault && rsp_page_fault)); // R6
  AST_UNIQUE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec_w)); // R8
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> valid_vec_w == '0); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready); // R10

endmodule

bind pg_xlate pg_xlate_chk #(
  .VA_W    (VA_W),
  .OFF_W   (OFF_W),
  .PA_W    (PA_W),
  .ENTRIES (ENTRIES)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .base_we        (base_we),
  .req_ready      (req_ready),
  .req_vaddr      (req_vaddr),
  .rsp_valid      (rsp_valid),
  .rsp_paddr      (rsp_paddr),
  .rsp_perm_fault (rsp_perm_fault),
  .rsp_page_fault (rsp_page_fault),
  .mem_rd_req     (mem_rd_req),
  .accept_w       (accept_w),
  .lk_hit_w       (lk_hit_w),
  .hit_vec_w      (hit_vec_w),
  .valid_vec_w    (valid_vec_w)
);

// File: tb/pg_xlate_tb_top.sv
module pg_xlate_tb_top;
  localparam int VPN_W = 4, OFF_W = 4, PFN_W = 4, ENTRIES = 4, MEM_AW = 8;
  localparam int VA_W = VPN_W + OFF_W, PA_W = PFN_W + OFF_W, PTE_W = PFN_W + 4;
  localparam int BASE0 = 'h20, BASE1 = 'h90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [MEM_AW-1:0] base_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic rsp_perm_fault, rsp_page_fault;
  logic mem_rd_req;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic mem_rsp_valid;
  logic [PTE_W-1:0] mem_rsp_data;

  always #10 clk = ~clk;

  pg_xlate #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .ENTRIES(ENTRIES), .MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm_fault(rsp_perm_fault),
    .rsp_page_fault(rsp_page_fault), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  // page-table word: valid above execute, write, read, frame
  function automatic logic [PTE_W-1:0] tbl_word(int tbl, int vpn);
    logic vld;
    int rights, frame;
    vld    = !((vpn == 13) || (tbl == 1 && vpn == 2));
    rights = (vpn + tbl) % 8;
    frame  = (vpn * 5 + 3 + tbl * 7) % 16;
    return {vld, 3'(rights), 4'(frame)};
  endfunction

  logic [PTE_W-1:0] mem [256];
  int  rd_cnt = 0;
  logic [MEM_AW-1:0] last_addr = '0;
  logic [MEM_AW-1:0] m_addr = '0;
  int  m_dly = 0;
  bit  m_pend = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend        <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_rd_req) begin
        rd_cnt    <= rd_cnt + 1;
        last_addr <= mem_rd_addr;
        m_addr    <= mem_rd_addr;
        m_dly     <= 1;
        m_pend    <= 1'b1;
      end else if (m_pend) begin
        if (m_dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[m_addr];
          m_pend        <= 1'b0;
        end else m_dly <= m_dly - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_base(input int b);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = MEM_AW'(b);
    #1;
    chk(req_ready == 1'b0, "R9 ready low during base write", int'(req_ready), 0);
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic xlate(input int vpn, input int off, input int kind,
                       output int pa, output int pf, output int pg,
                       output int nrd, output int ncyc, output int busy_seen);
    int r0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rd_cnt;
    req_valid = 1'b1;
    req_vaddr = {VPN_W'(vpn), OFF_W'(off)};
    req_kind  = 2'(kind);
    @(negedge clk);
    req_valid = 1'b0;
    ncyc = 1;
    busy_seen = (!rsp_valid && !req_ready) ? 1 : 0;
    while (!rsp_valid && ncyc < 50) begin
      @(negedge clk);
      ncyc++;
    end
    pa  = int'(rsp_paddr);
    pf  = int'(rsp_perm_fault);
    pg  = int'(rsp_page_fault);
    nrd = rd_cnt - r0;
  endtask

  task automatic expect_result(input int tbl, input int vpn, input int off, input int kind,
                               output int pa, output int pf, output int pg);
    logic [PTE_W-1:0] w;
    w = tbl_word(tbl, vpn);
    pa = 0; pf = 0; pg = 0;
    if (!w[PTE_W-1]) pg = 1;
    else if (kind == 3 || !w[PFN_W + kind]) pf = 1;
    else pa = int'(w[PFN_W-1:0]) * 16 + off;
  endtask

  task automatic run_one(input int tbl, input int vpn, input int off, input int kind,
                         input int exp_rd, input bit hitcheck);
    int pa, pf, pg, nrd, ncyc, bs, epa, epf, epg;
    xlate(vpn, off, kind, pa, pf, pg, nrd, ncyc, bs);
    expect_result(tbl, vpn, off, kind, epa, epf, epg);
    chk(pg == epg, "R6 page fault flag", pg, epg);
    chk(pf == epf, "R5 permission fault flag", pf, epf);
    chk(pa == epa, "R1 R4 physical address", pa, epa);
    if (exp_rd >= 0) chk(nrd == exp_rd, "R3 R7 table reads", nrd, exp_rd);
    if (hitcheck && exp_rd == 0) chk(ncyc == 1, "R2 hit latency", ncyc, 1);
    if (exp_rd == 1) begin
      chk(bs == 1, "R10 ready low during walk", bs, 1);
      chk(int'(last_addr) == ((tbl == 0 ? BASE0 : BASE1) + vpn), "R3 read address",
          int'(last_addr), (tbl == 0 ? BASE0 : BASE1) + vpn);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = '0;
    for (int v = 0; v < 16; v++) begin
      mem[BASE0 + v] = tbl_word(0, v);
      mem[BASE1 + v] = tbl_word(1, v);
    end
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 rsp_valid after reset", int'(rsp_valid), 0);
    chk(mem_rd_req == 1'b0, "R11 no read after reset", int'(mem_rd_req), 0);
    chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);

    // first access after reset must miss: cache starts empty (R11)
    set_base(BASE0);
    // full sweep of table 0: per page a flush, then every kind and offset
    for (int v = 0; v < 16; v++) begin
      set_base(BASE0);
      for (int k = 0; k < 4; k++) begin
        for (int o = 0; o < 16; o++) begin
          int erd;
          logic [PTE_W-1:0] w;
          w = tbl_word(0, v);
          if (k == 0 && o == 0) erd = 1;
          else erd = w[PTE_W-1] ? 0 : 1; // R6 invalid not cached, R7 valid cached
          run_one(0, v, o, k, erd, 1'b1);
        end
      end
    end

    // switch to table 1: every page must be fetched again (R9)
    set_base(BASE1);
    for (int v = 0; v < 16; v++) run_one(1, v, 5, 0, 1, 1'b0);

    // replacement order R8 on table 1: A=0 B=1 C=3 D=4 E=5
    set_base(BASE1);
    run_one(1, 0, 1, 0, 1, 1'b0);
    run_one(1, 1, 2, 0, 1, 1'b0);
    run_one(1, 3, 3, 0, 1, 1'b0);
    run_one(1, 4, 4, 0, 1, 1'b0);
    run_one(1, 5, 5, 0, 1, 1'b0); // evicts A (slot 0)
    run_one(1, 4, 6, 0, 0, 1'b1);
    run_one(1, 3, 7, 0, 0, 1'b1);
    run_one(1, 1, 8, 0, 0, 1'b1);
    run_one(1, 0, 9, 0, 1, 1'b0); // evicts B (slot 1)
    run_one(1, 1, 10, 0, 1, 1'b0); // evicts C (slot 2)
    run_one(1, 4, 11, 0, 0, 1'b1);
    run_one(1, 5, 12, 0, 0, 1'b1);
    run_one(1, 3, 13, 0, 1, 1'b0); // evicts D (slot 3)
    run_one(1, 5, 14, 0, 0, 1'b1);
    run_one(1, 0, 15, 0, 0, 1'b1);
    run_one(1, 4, 0, 0, 1, 1'b0);  // D gone, pointer wrapped to slot 0

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule